// File: doc/BRIEF.md
# GPIO Line Interrupt Controller

This block watches the input lines of a GPIO bank and turns their activity into a single interrupt request for a parent interrupt controller. Each line has its own detection mode: active-high level, active-low level, rising edge, falling edge, or either edge. Edge events are held in a per-line latch until software clears them. Level conditions are not latched. They follow the synchronised pin.

Software reaches the block through a small 16-bit register port with an address, a write strobe, a read strobe and write and read data. Three configuration registers set the detection mode of each line: an edge-enable word, a dual-edge word and a polarity word. A mask word and a pending word sit alongside them, with two clear registers. The plain clear register only drops latched events. The clear-and-disable register drops the latched events and also sets the mask bits of the same lines. The interrupt output is one registered, active-high level signal. It is high whenever any unmasked line is active. The register port is plain control access with no handshake: a write takes effect on the clock edge where the write strobe is high, and read data is registered on the edge where the read strobe is high.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the mask word reads 0xFFFF. The edge-enable, dual-edge, polarity and pending words read 0, and `irq` is 0.
- R2: Writes to offset 0x4 (edge-enable), 0x6 (dual-edge), 0x8 (polarity) and 0xA (mask) read back unchanged. Reads of offsets 0x0 and 0x2 always return 0. Bit n of every word belongs to line n.
- R3: A line with edge-enable 0 and dual-edge 0 is a level line. With polarity 1 it is active while its synchronised input is 1. With polarity 0 it is active while its input is 0. Nothing is latched, and clear writes have no effect on it.
- R4: A line with edge-enable 1 and dual-edge 0 latches an event on a 0-to-1 input transition when polarity is 1, and on a 1-to-0 transition when polarity is 0.
- R5: A line with edge-enable 1 and dual-edge 1 latches an event on any input transition, whatever its polarity bit.
- R6: A latched event stays set until a write to offset 0x0 with a 1 in that line's bit. Bits written as 0 leave their latch untouched.
- R7: A write to offset 0x2 clears the latch of every line written as 1 and sets the mask bit of that line, in the same cycle.
- R8: A mask bit of 1 keeps its line out of the pending word and out of `irq`. Edge events are still latched while masked and appear once the mask bit is cleared.
- R9: If an edge event and a clear of the same line fall in the same cycle, the latch stays set.
- R10: Offset 0xC reads the set of active, unmasked lines. `irq` is the OR of those bits, registered one cycle later.
- R11: Each input passes through a two-flop synchroniser. After an input change between edges, a level line becomes active after the second rising edge and `irq` follows on the third. An edge line latches on the third edge and `irq` follows on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | 16 | Asynchronous GPIO line inputs |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered on the strobed edge |
| irq | output | 1 | Active-high level interrupt to the parent |

## Verification
Each of the five detection modes is driven with steady highs, steady lows, rising and falling transitions. This separates the level lines, which track the pin and forget it, from the edge lines, which remember one direction or both. A long random mix of configuration writes, pin toggles, clears, clear-and-disable writes and reads tests the latch-versus-level split and mask gating against a bench model. Directed cases pin down the exact synchroniser latency, an edge that lands on the same cycle as its clear, and events caught while masked that surface on unmask.

// File: rtl/gic_pkg.sv
package gic_pkg;
  localparam int unsigned LINES  = 16;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] OFS_CLR     = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CLR_DIS = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_EDGE    = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_DUAL    = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_POL     = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 4'hA;
  localparam logic [ADDR_W-1:0] OFS_PEND    = 4'hC;

  typedef struct packed {
    logic edge_en;
    logic dual;
    logic pol;
  } sense_t;
endpackage

// File: rtl/gic_sync.sv
module gic_sync #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gic_line.sv
module gic_line
  import gic_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pin_s,
  input  sense_t sense,
  input  logic   clr,
  output logic   active
);
  logic prev_q;
  logic latch_q;
  logic evt;
  logic rise, fall;

  assign rise = pin_s & ~prev_q;
  assign fall = ~pin_s & prev_q;

  always_comb begin
    if (!sense.edge_en)   evt = 1'b0;
    else if (sense.dual)  evt = rise | fall;
    else if (sense.pol)   evt = rise;
    else                  evt = fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= pin_s;
      latch_q <= sense.edge_en & (evt | (latch_q & ~clr));
    end
  end

  assign active = sense.edge_en ? latch_q : ~(pin_s ^ sense.pol);

  // R9: a new edge survives a simultaneous clear
  p_edge_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && sense.edge_en) |=> latch_q);
  // R6: a clear with no new edge drops the latch
  p_clear_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !latch_q);
  // R6: without clear or event the latch holds
  p_latch_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && !clr && sense.edge_en) |=> latch_q);
endmodule

// File: rtl/gic_regs.sv
module gic_regs
  import gic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LINES-1:0]  pending,
  output logic [DATA_W-1:0] rdata,
  output logic [LINES-1:0]  edge_en,
  output logic [LINES-1:0]  dual,
  output logic [LINES-1:0]  pol,
  output logic [LINES-1:0]  mask,
  output logic [LINES-1:0]  clr
);
  logic wr_clr, wr_clr_dis;
  logic [DATA_W-1:0] rd_mux;

  assign wr_clr     = wr && (addr == OFS_CLR);
  assign wr_clr_dis = wr && (addr == OFS_CLR_DIS);
  assign clr        = (wr_clr || wr_clr_dis) ? wdata[LINES-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_en <= '0;
      dual    <= '0;
      pol     <= '0;
      mask    <= '1;
    end else if (wr) begin
      unique case (addr)
        OFS_EDGE:    edge_en <= wdata[LINES-1:0];
        OFS_DUAL:    dual    <= wdata[LINES-1:0];
        OFS_POL:     pol     <= wdata[LINES-1:0];
        OFS_MASK:    mask    <= wdata[LINES-1:0];
        OFS_CLR_DIS: mask    <= mask | wdata[LINES-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (addr)
      OFS_EDGE: rd_mux[LINES-1:0] = edge_en;
      OFS_DUAL: rd_mux[LINES-1:0] = dual;
      OFS_POL:  rd_mux[LINES-1:0] = pol;
      OFS_MASK: rd_mux[LINES-1:0] = mask;
      OFS_PEND: rd_mux[LINES-1:0] = pending;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_mux;
  end

  // R7: clear-and-disable sets every written mask bit
  p_clrdis_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr_dis |=> ((mask & $past(wdata[LINES-1:0])) == $past(wdata[LINES-1:0])));
  // R2: the clear offsets read as zero
  p_clr_reads_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (addr == OFS_CLR || addr == OFS_CLR_DIS)) |=> (rdata == '0));
  // R8: masked lines never show in the pending readout
  p_pend_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && addr == OFS_PEND) |=> ((rdata[LINES-1:0] & $past(mask)) == '0));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINES-1:0]  gpio_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [LINES-1:0] pin_s;
  logic [LINES-1:0] edge_en, dual, pol, mask, clr;
  logic [LINES-1:0] active, pending;
  logic             irq_q;

  gic_sync #(.WIDTH(LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(gpio_in), .dout(pin_s)
  );

  gic_regs u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .pending(pending), .rdata(bus_rdata),
    .edge_en(edge_en), .dual(dual), .pol(pol), .mask(mask), .clr(clr)
  );

  for (genvar n = 0; n < LINES; n++) begin : g_line
    sense_t s;
    assign s = '{edge_en: edge_en[n], dual: dual[n], pol: pol[n]};
    gic_line u_line (
      .clk(clk), .rst_n(rst_n), .pin_s(pin_s[n]), .sense(s),
      .clr(clr[n]), .active(active[n])
    );
  end

  assign pending = active & ~mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |pending;
  end

  assign irq = irq_q;

  // R10: the output is the registered OR of the pending set
  p_irq_tracks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|pending));
  // R3: level lines follow the synchronised pin against polarity
  p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pending & ~edge_en) == ((~(pin_s ^ pol)) & ~edge_en & ~mask)));
endmodule

// File: tb/test_gpio_irq_ctrl.sv
module test_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] gpio_in = '0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        irq;

  int unsigned vectors = 0;
  int unsigned errors  = 0;

  logic [15:0] m_edge = '0, m_dual = '0, m_pol = '0, m_mask = '1, m_lat = '0, m_in = '0;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] exp_pend();
    logic [15:0] lvl;
    lvl = ~m_edge & ~(m_in ^ m_pol);
    return ((m_edge & m_lat) | lvl) & ~m_mask;
  endfunction

  function automatic logic [15:0] edge_events(logic [15:0] o, logic [15:0] n);
    return m_edge & ((m_dual & (o ^ n)) |
                     (~m_dual & m_pol & n & ~o) |
                     (~m_dual & ~m_pol & ~n & o));
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      4'h0: m_lat &= ~d;
      4'h2: begin m_lat &= ~d; m_mask |= d; end
      4'h4: m_edge = d;
      4'h6: m_dual = d;
      4'h8: m_pol = d;
      4'hA: m_mask = d;
      default: ;
    endcase
    m_lat &= m_edge;
    @(negedge clk);
  endtask

  task automatic bus_read(logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic drive(logic [15:0] v);
    @(negedge clk);
    m_lat |= edge_events(m_in, v);
    m_in = v;
    gpio_in = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_pend(string req);
    logic [15:0] d;
    bus_read(4'hC, d);
    check(req, d, exp_pend());
    check(req, {15'd0, irq}, {15'd0, |exp_pend()});
  endtask

  initial begin
    logic [15:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 irq", {15'd0, irq}, 16'd0);
    bus_read(4'hA, d); check("R1 mask", d, 16'hFFFF);
    bus_read(4'h4, d); check("R1 edge", d, 16'h0000);
    bus_read(4'h6, d); check("R1 dual", d, 16'h0000);
    bus_read(4'h8, d); check("R1 pol", d, 16'h0000);
    bus_read(4'hC, d); check("R1 pend", d, 16'h0000);

    // R2 readback and zero-reading clear offsets
    bus_write(4'h4, 16'hA5C3); bus_read(4'h4, d); check("R2 edge", d, 16'hA5C3);
    bus_write(4'h6, 16'h3C5A); bus_read(4'h6, d); check("R2 dual", d, 16'h3C5A);
    bus_write(4'h8, 16'h0FF0); bus_read(4'h8, d); check("R2 pol", d, 16'h0FF0);
    bus_write(4'hA, 16'hF00F); bus_read(4'hA, d); check("R2 mask", d, 16'hF00F);
    bus_read(4'h0, d); check("R2 clr reads 0", d, 16'h0);
    bus_read(4'h2, d); check("R2 clrdis reads 0", d, 16'h0);

    // setup: all edge-free, line0 level-high, unmasked
    bus_write(4'h4, 16'h0000); bus_write(4'h6, 16'h0000);
    bus_write(4'h8, 16'hFFFF); bus_write(4'hA, 16'hFFFE);
    // R11 latency for a level line
    @(negedge clk); gpio_in = 16'h0001; m_in = 16'h0001;
    @(negedge clk); check("R11 lvl N1", {15'd0, irq}, 16'd0);
    @(negedge clk); check("R11 lvl N2", {15'd0, irq}, 16'd0);
    @(negedge clk); check("R11 lvl N3", {15'd0, irq}, 16'd1);
    // R3 clear has no effect on level line; drop releases it
    bus_write(4'h0, 16'h0001); check_pend("R3 clr ignored");
    drive(16'h0000); check_pend("R3 no latch");
    bus_write(4'h8, 16'hFFFE); check_pend("R3 level low");

    // R4 rising on line1, falling on line2
    bus_write(4'h8, 16'hFFFB); bus_write(4'h4, 16'h0006); bus_write(4'hA, 16'hFFF9);
    drive(16'h0002); check_pend("R4 rise");
    drive(16'h0000); check_pend("R4 fall ignored by rise line");
    drive(16'h0004); check_pend("R4 rise ignored by fall line");
    drive(16'h0000); check_pend("R4 fall");
    // R6 clear with zeros then ones
    bus_write(4'h0, 16'h0000); check_pend("R6 zero clear");
    bus_write(4'h0, 16'h0002); check_pend("R6 clear line1");
    bus_write(4'h0, 16'h0004); check_pend("R6 clear line2");

    // R5 dual edge on line3, polarity both ways
    bus_write(4'h4, 16'h0008); bus_write(4'h6, 16'h0008); bus_write(4'hA, 16'hFFF7);
    bus_write(4'h8, 16'h0000);
    drive(16'h0008); check_pend("R5 rise pol0");
    bus_write(4'h0, 16'h0008); bus_write(4'h8, 16'h0008);
    drive(16'h0000); check_pend("R5 fall pol1");

    // R7 clear-and-disable
    bus_write(4'h2, 16'h0008); check_pend("R7 cleared");
    bus_read(4'hA, d); check("R7 mask set", d, m_mask);

    // R8 latched while masked, shows on unmask
    drive(16'h0008); check_pend("R8 masked hidden");
    bus_write(4'hA, 16'hFFF7); check_pend("R8 unmask reveals");
    bus_write(4'h0, 16'h0008);

    // R9 edge and clear in the same cycle: line3 latched, then edge+clear
    drive(16'h0000); // latches falling (dual)
    @(negedge clk); gpio_in = 16'h0008;
    @(negedge clk);
    @(negedge clk); bus_addr = 4'h0; bus_wdata = 16'h0008; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    m_lat &= ~16'h0008; m_lat |= edge_events(m_in, 16'h0008); m_in = 16'h0008;
    repeat (2) @(negedge clk);
    check_pend("R9 edge wins");
    bus_write(4'h0, 16'h0008); check_pend("R9 cleared after");

    // random mix, R10 pending/irq agreement
    for (int it = 0; it < 400; it++) begin
      int unsigned op;
      op = $urandom % 6;
      case (op)
        0: bus_write(4'h4, 16'($urandom));
        1: bus_write(4'h6, 16'($urandom));
        2: bus_write(4'h8, 16'($urandom));
        3: bus_write(4'hA, 16'($urandom));
        4: begin
          if ($urandom % 2) bus_write(4'h0, 16'($urandom));
          else bus_write(4'h2, 16'($urandom) & 16'($urandom));
        end
        default: drive(m_in ^ (16'h1 << ($urandom % 16)) ^ ((($urandom % 4) == 0) ? 16'($urandom) : 16'h0));
      endcase
      check_pend("R10 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule